// File: doc/BRIEF.md
# Up/Down Timer with Filtered Update Events

This block is a general-purpose counter with a programmable clock divider and a reload limit. Software writes the reload limit and the divide ratio into holding registers. They only reach the active copies that steer counting when an update event is generated. The counter runs up or down, and can stop by itself after one period. It can also be started by an external trigger line.

An update event has several possible causes: the counter wrapping at either end, a software strobe, or an external slave reset. Two controls filter the event. The first, an update-block bit, suppresses the event entirely. The strobe and the slave reset still restart the counter and the divider when the event is suppressed. The second, an overflow-only bit, lets every event copy the holding registers but limits the sticky interrupt flag and the DMA request pulse to counter wraps.

Top module: `updn_timer`

## Requirements
- R1: After reset the count is 0, the run bit, update pulse, flag and DMA request are 0, the active reload value is all ones and the active divide value is 0.
- R2: With the down bit 0, each counter tick adds 1. A tick taken while the count equals the active reload value sets the count to 0 and is an overflow that generates an update event.
- R3: With the down bit 1, each counter tick subtracts 1. A tick taken while the count is 0 loads the reload value and is an underflow that generates an update event.
- R4: The counter and divider advance only while the run bit is 1. A control write sets the run bit to the written value. A pulse on slave_start sets it to 1 in the following cycle.
- R5: With an active divide value D, the counter ticks once every D+1 running cycles. The first tick after a restart falls D+1 cycles after it.
- R6: Writes to the reload or divide holding register leave the active values and counting unchanged. An update event copies both holding registers into the active values.
- R7: A sw_update or slave_reset pulse clears the divider. It sets the count to 0 when counting up, or to the reload value when counting down. When updates are not blocked, the pulse is also an update event.
- R8: With the overflow-only bit 0, every update event sets the flag and, if dma_en is 1, the DMA request. With the bit 1, only overflow or underflow events do so. Other events still reload the active values.
- R9: With the update-block bit 1, no update pulse occurs and the active values keep their contents. Wraps and restart pulses still act on the count.
- R10: The update flag stays 1 until a flag_clr pulse clears it. The DMA request is a single-cycle pulse that occurs only when dma_en is 1.
- R11: With the single-period bit 1, the update event clears the run bit, so the counter holds at its reloaded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Write strobe for the five control bits |
| ctl_run | input | 1 | Run bit value to write |
| ctl_down | input | 1 | Direction value to write (1 = down) |
| ctl_single | input | 1 | Single-period bit value to write |
| ctl_ovf_only | input | 1 | Overflow-only request bit value to write |
| ctl_upd_off | input | 1 | Update-block bit value to write |
| reload_wr | input | 1 | Write strobe for the reload holding register |
| reload_wdata | input | W | Reload holding value |
| div_wr | input | 1 | Write strobe for the divide holding register |
| div_wdata | input | W | Divide holding value |
| sw_update | input | 1 | Software update/restart strobe |
| slave_reset | input | 1 | External restart request |
| slave_start | input | 1 | External start trigger |
| flag_clr | input | 1 | Clears the update flag |
| dma_en | input | 1 | Enables the DMA request pulse |
| count | output | W | Current count |
| running | output | 1 | Run bit |
| update_pulse | output | 1 | One cycle per update event |
| update_flag | output | 1 | Sticky update interrupt flag |
| dma_req | output | 1 | Update DMA request pulse |
| reload_active | output | W | Active reload value |
| div_active | output | W | Active divide value |

## Verification
Some properties are checked on every cycle. The active reload value never changes without an update event. No update pulse appears while updates are blocked, and a DMA pulse only follows an enabled cycle. A rising flag always traces back to a wrap or to an unfiltered source. The divider phase never passes the divide value, a down tick below a nonzero count subtracts one, and a single-period update stops the run bit. Other behaviour can only be shown by the bench's scenarios. These cover the exact cycle of each wrap at the reload value in both directions and the values restored by a restart. They also cover the delay before a newly written divide ratio takes effect, flag stickiness and the hand-off from an external start.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;

    typedef struct packed {
        logic run;
        logic down;
        logic single;
        logic ovf_only;
        logic upd_off;
    } tmr_ctl_t;

endpackage

// File: rtl/updn_timer_regs.sv
module updn_timer_regs
    import updn_timer_pkg::*;
#(
    parameter int W = 16,
    parameter logic [W-1:0] RST_RELOAD = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr,
    input  tmr_ctl_t     ctl_wdata,
    input  logic         start,
    input  logic         reload_wr,
    input  logic [W-1:0] reload_wdata,
    input  logic         div_wr,
    input  logic [W-1:0] div_wdata,
    input  logic         uev,
    output tmr_ctl_t     ctl,
    output logic [W-1:0] reload_act,
    output logic [W-1:0] reload_next,
    output logic [W-1:0] div_act
);

    typedef struct packed {
        tmr_ctl_t     ctl;
        logic [W-1:0] rl_pre;
        logic [W-1:0] rl_act;
        logic [W-1:0] dv_pre;
        logic [W-1:0] dv_act;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_wr) st_d.ctl = ctl_wdata;
        if (start) st_d.ctl.run = 1'b1;
        if (uev && st_q.ctl.single) st_d.ctl.run = 1'b0;
        if (reload_wr) st_d.rl_pre = reload_wdata;
        if (div_wr) st_d.dv_pre = div_wdata;
        if (uev) begin
            st_d.rl_act = st_q.rl_pre;
            st_d.dv_act = st_q.dv_pre;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.rl_pre <= RST_RELOAD;
            st_q.rl_act <= RST_RELOAD;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl         = st_q.ctl;
    assign reload_act  = st_q.rl_act;
    assign div_act     = st_q.dv_act;
    assign reload_next = uev ? st_q.rl_pre : st_q.rl_act;

    // R6: active copies move only on an update event
    p_shadow_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !uev |=> ($stable(reload_act) && $stable(div_act)));

    // R11: single-period update stops the counter
    p_single_stop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (uev && ctl.single) |=> !ctl.run);

endmodule

// File: rtl/updn_timer_presc.sv
module updn_timer_presc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         restart,
    input  logic [W-1:0] div_act,
    output logic         tick
);

    typedef struct packed {
        logic [W-1:0] phase;
    } presc_t;

    presc_t st_d, st_q;

    assign tick = run && (st_q.phase == div_act);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.phase = '0;
        end else if (run) begin
            st_d.phase = tick ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: divider phase never runs past the divide value
    p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= div_act);

endmodule

// File: rtl/updn_timer_core.sv
module updn_timer_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         down,
    input  logic         restart,
    input  logic [W-1:0] reload_act,
    input  logic [W-1:0] reload_next,
    output logic [W-1:0] count,
    output logic         wrap
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } core_t;

    core_t st_d, st_q;
    logic  at_end;

    assign at_end = down ? (st_q.cnt == '0) : (st_q.cnt == reload_act);
    assign wrap   = tick && at_end;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = down ? reload_next : '0;
        end else if (tick) begin
            if (down) st_d.cnt = at_end ? reload_next : st_q.cnt - 1'b1;
            else      st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.cnt;

    // R3: a down tick above zero subtracts one
    p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down && !restart && count != '0) |=> (count == W'($past(count) - 1'b1)));

endmodule

// File: rtl/updn_timer_upd.sv
module updn_timer_upd (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap,
    input  logic restart,
    input  logic ovf_only,
    input  logic upd_off,
    input  logic flag_clr,
    input  logic dma_en,
    output logic uev,
    output logic uev_pulse,
    output logic flag,
    output logic dma_req
);

    typedef struct packed {
        logic uev;
        logic flag;
        logic dma;
    } upd_t;

    upd_t st_d, st_q;
    logic req;

    assign uev = !upd_off && (wrap || restart);
    assign req = uev && (wrap || !ovf_only);

    always_comb begin
        st_d     = st_q;
        st_d.uev = uev;
        st_d.dma = req && dma_en;
        if (flag_clr) st_d.flag = 1'b0;
        if (req)      st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign uev_pulse = st_q.uev;
    assign flag      = st_q.flag;
    assign dma_req   = st_q.dma;

    // R9: blocked updates never pulse
    p_no_uev_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        upd_off |=> !uev_pulse);

    // R10: DMA pulse only after an enabled cycle
    p_dma_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |-> $past(dma_en));

    // R8: flag rises only from a wrap or an unfiltered source
    p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(wrap) || !$past(ovf_only)));

endmodule

// File: rtl/updn_timer.sv
module updn_timer
    import updn_timer_pkg::*;
#(
    parameter int W = 16,
    parameter logic [W-1:0] RST_RELOAD = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_wr,
    input  logic         ctl_run,
    input  logic         ctl_down,
    input  logic         ctl_single,
    input  logic         ctl_ovf_only,
    input  logic         ctl_upd_off,
    input  logic         reload_wr,
    input  logic [W-1:0] reload_wdata,
    input  logic         div_wr,
    input  logic [W-1:0] div_wdata,
    input  logic         sw_update,
    input  logic         slave_reset,
    input  logic         slave_start,
    input  logic         flag_clr,
    input  logic         dma_en,
    output logic [W-1:0] count,
    output logic         running,
    output logic         update_pulse,
    output logic         update_flag,
    output logic         dma_req,
    output logic [W-1:0] reload_active,
    output logic [W-1:0] div_active
);

    tmr_ctl_t     ctl_wdata, ctl;
    logic         restart, uev, tick, wrap;
    logic [W-1:0] reload_next;

    assign ctl_wdata = '{run: ctl_run, down: ctl_down, single: ctl_single,
                         ovf_only: ctl_ovf_only, upd_off: ctl_upd_off};
    assign restart   = sw_update || slave_reset;

    updn_timer_regs #(.W(W), .RST_RELOAD(RST_RELOAD)) u_regs (
        .clk, .rst_n, .ctl_wr, .ctl_wdata, .start(slave_start),
        .reload_wr, .reload_wdata, .div_wr, .div_wdata, .uev,
        .ctl, .reload_act(reload_active), .reload_next, .div_act(div_active)
    );

    updn_timer_presc #(.W(W)) u_presc (
        .clk, .rst_n, .run(ctl.run), .restart, .div_act(div_active), .tick
    );

    updn_timer_core #(.W(W)) u_core (
        .clk, .rst_n, .tick, .down(ctl.down), .restart,
        .reload_act(reload_active), .reload_next, .count, .wrap
    );

    updn_timer_upd u_upd (
        .clk, .rst_n, .wrap, .restart, .ovf_only(ctl.ovf_only),
        .upd_off(ctl.upd_off), .flag_clr, .dma_en, .uev,
        .uev_pulse(update_pulse), .flag(update_flag), .dma_req
    );

    assign running = ctl.run;

endmodule

// File: tb/updn_timer_test.sv
`timescale 1ns/1ps
module updn_timer_test;

    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_wr = 0, ctl_run = 0, ctl_down = 0, ctl_single = 0, ctl_ovf_only = 0, ctl_upd_off = 0;
    logic reload_wr = 0, div_wr = 0;
    logic [W-1:0] reload_wdata = '0, div_wdata = '0;
    logic sw_update = 0, slave_reset = 0, slave_start = 0, flag_clr = 0, dma_en = 0;
    logic [W-1:0] count, reload_active, div_active;
    logic running, update_pulse, update_flag, dma_req;

    always #2.5 clk = ~clk;

    updn_timer #(.W(W)) uut (.*);

    typedef struct {
        logic [W-1:0] cnt;
        logic         dma;
        string        tag;
    } exp_t;

    exp_t sb[$];
    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_uev(logic [W-1:0] c, logic d, string tag);
        exp_t e;
        e.cnt = c; e.dma = d; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: every update pulse is matched against the scoreboard
    always @(negedge clk) begin
        if (rst_n && update_pulse) begin
            if (sb.size() == 0) begin
                chk("R9 unexpected update", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk({e.tag, " count"}, count, e.cnt);
                chk({e.tag, " dma"}, dma_req, e.dma);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ctl(logic r, logic d, logic s, logic o, logic u);
        ctl_wr = 1; ctl_run = r; ctl_down = d; ctl_single = s; ctl_ovf_only = o; ctl_upd_off = u;
        step(1);
        ctl_wr = 0;
    endtask

    task automatic pulse_ug();   sw_update = 1;   step(1); sw_update = 0;   endtask
    task automatic pulse_slv();  slave_reset = 1; step(1); slave_reset = 0; endtask
    task automatic pulse_start(); slave_start = 1; step(1); slave_start = 0; endtask
    task automatic pulse_clr();  flag_clr = 1;    step(1); flag_clr = 0;    endtask
    task automatic write_reload(logic [W-1:0] v); reload_wr = 1; reload_wdata = v; step(1); reload_wr = 0; endtask
    task automatic write_div(logic [W-1:0] v);    div_wr = 1;    div_wdata = v;    step(1); div_wr = 0;    endtask

    initial begin
        #(5.0 * 50000);
        if (!finished) begin
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1;
        step(1);
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 run", running, 0);
        chk("R1 flag", update_flag, 0);
        chk("R1 dma", dma_req, 0);
        chk("R1 pulse", update_pulse, 0);
        chk("R1 reload", reload_active, 16'hFFFF);
        chk("R1 div", div_active, 0);

        // R6 holding writes have no effect before an update
        write_reload(4);
        write_div(0);
        chk("R6 reload held", reload_active, 16'hFFFF);

        // R7 strobe is an update and restarts; R8 strobe raises flag
        expect_uev(0, 0, "R7");
        pulse_ug();
        chk("R6 reload copied", reload_active, 4);
        chk("R8 flag from strobe", update_flag, 1);
        pulse_clr();
        chk("R10 flag cleared", update_flag, 0);

        // R2 up count, wrap at reload 4
        expect_uev(0, 0, "R2");
        set_ctl(1, 0, 0, 0, 0);
        chk("R4 running", running, 1);
        chk("R2 count0", count, 0);
        step(3);
        chk("R2 count3", count, 3);
        step(1);
        chk("R2 count4", count, 4);
        step(1);
        chk("R2 wrapped", count, 0);
        chk("R2 flag", update_flag, 1);
        set_ctl(0, 0, 0, 1, 0);
        chk("R4 stopped", count, 1);
        pulse_clr();

        // R8 overflow-only: strobe updates but raises nothing
        dma_en = 1;
        expect_uev(0, 0, "R8");
        pulse_ug();
        chk("R8 flag filtered", update_flag, 0);
        chk("R8 dma filtered", dma_req, 0);
        expect_uev(0, 1, "R8");
        set_ctl(1, 0, 0, 1, 0);
        step(5);
        chk("R8 flag on wrap", update_flag, 1);
        chk("R10 dma pulse", dma_req, 1);
        set_ctl(0, 0, 0, 0, 1);
        chk("R10 dma one cycle", dma_req, 0);
        chk("R10 flag sticky", update_flag, 1);
        pulse_clr();

        // R9 updates blocked: restart still works, actives held
        write_reload(6);
        pulse_ug();
        chk("R9 restart count", count, 0);
        chk("R9 reload held", reload_active, 4);
        chk("R9 flag", update_flag, 0);
        set_ctl(1, 0, 0, 0, 1);
        step(5);
        chk("R9 wrap no update", count, 0);
        chk("R9 reload kept", reload_active, 4);
        set_ctl(0, 0, 0, 0, 0);
        chk("R4 stop count", count, 1);
        step(3);
        chk("R4 hold while stopped", count, 1);

        // R7 slave reset is an update
        expect_uev(0, 1, "R7");
        pulse_slv();
        chk("R7 slave count", count, 0);
        chk("R7 slave reload", reload_active, 6);
        chk("R8 flag from slave", update_flag, 1);
        pulse_clr();

        // R3 + R11 down single period
        set_ctl(0, 1, 1, 0, 0);
        expect_uev(6, 1, "R7");
        pulse_ug();
        chk("R7 down restart", count, 6);
        pulse_clr();
        set_ctl(1, 1, 1, 0, 0);
        chk("R3 start", count, 6);
        step(2);
        chk("R3 count4", count, 4);
        expect_uev(6, 1, "R3");
        step(4);
        chk("R3 count0", count, 0);
        step(1);
        chk("R3 underflow reload", count, 6);
        chk("R11 run cleared", running, 0);
        step(3);
        chk("R11 held", count, 6);

        // R4 external start
        pulse_start();
        chk("R4 slave start", running, 1);
        chk("R4 start count", count, 6);
        step(1);
        chk("R4 count5", count, 5);
        set_ctl(0, 1, 0, 0, 0);
        chk("R4 stop", count, 4);

        // R5 divider
        pulse_clr();
        write_div(2);
        chk("R6 div held", div_active, 0);
        expect_uev(6, 1, "R5");
        pulse_ug();
        chk("R6 div copied", div_active, 2);
        set_ctl(1, 1, 0, 0, 0);
        chk("R5 c0", count, 6);
        step(2);
        chk("R5 no tick yet", count, 6);
        step(1);
        chk("R5 first tick", count, 5);
        step(2);
        chk("R5 between ticks", count, 5);
        step(1);
        chk("R5 second tick", count, 4);
        set_ctl(0, 1, 0, 0, 0);

        step(2);
        chk("R2 scoreboard drained", sb.size(), 0);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule